// File: doc/BRIEF.md
# Selectable ECC / Byte-Parity Memory Checker

This block sits in a memory controller, between the host and a 64-bit memory path. That path is built from two interleaved 32-bit banks, and each matched module pair supplies both banks. On the write path it splits the host word across the two banks and produces eight check bits. On the read path it reassembles the word, checks it and corrects it, then returns it one cycle later. The latency is the same whether the word was clean, corrected or bad.

A run-time mode input selects the checking method for the whole memory. The first method is a single-error-correcting, double-error-detecting code of the odd-weight-column family. The second is plain byte parity. The code is used only for module pairs flagged as matched. Unmatched pairs always fall back to parity.

A correctable error is fixed without a stall and counted. An uncorrectable error raises a sticky halt request. When it occurs in code mode, it also sets the failing pair's bit in a pair-disable register. The address of the first erroneous access is held in a sticky register, which firmware can clear together with the counter.

Top module: `mck_top`

## Requirements
- R1: The write check byte depends on the effective mode. In parity mode, check bit k is the XOR of data byte k (bits 8k+7..8k), which is even parity. In code mode, check bit r is the XOR of every data bit i whose column has bit r set. Data bit i for i<56 takes the i-th weight-3 8-bit value in ascending numeric order. Data bits 56..63 take the weight-5 values in ascending order. Each check bit's own column is the unit vector of that bit.
- R2: Address bit 0 selects the bank ordering. When it is 0, bank 0 carries data[31:0] and bank 1 carries data[63:32]. When it is 1, the halves are swapped. Reads reassemble the word with the same rule.
- R3: Every read with rd_valid_i high gives exactly one rsp_valid_o pulse on the next cycle, with no extra delay for corrected or bad words. There is no response in a cycle without a read.
- R4: In code mode, a single flipped bit anywhere in the 72-bit codeword (data bits 0..63, check bits 64..71) is corrected. Such a read returns the original data with rsp_corrected_o=1 and rsp_err_o=0.
- R5: In code mode, a double-bit error returns rsp_err_o=1 with the raw data. halt_o then rises in the same cycle and stays high until reset.
- R6: An uncorrectable error in code mode sets bit p of pair_disable_o, where p = address bits [ADDR_W-1 -: log2(NPAIRS)]. Other bits are left unchanged, and set bits are cleared only by reset.
- R7: In parity mode, a byte whose parity (including its check bit) is odd gives rsp_err_o=1 and raises halt_o. The raw data is returned with no correction and no pair-disable update. An even number of flips within one byte goes unseen.
- R8: For a pair whose pair_matched_i bit is 0, the mode input is ignored, and both the write check byte and the read check use parity.
- R9: ce_count_o adds one per corrected response and saturates at 2^CNT_W-1. clear_i sets it to 0.
- R10: After reset or clear_i, the address of the first response with an error (corrected or not) is captured in err_addr_o and err_valid_o is set. Later errors do not overwrite it. clear_i drops err_valid_o but leaves halt_o set.
- R11: A clean read returns the data unchanged with both flags low. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_mode_i | input | 1 | 1 = code mode for matched pairs, 0 = byte parity |
| pair_matched_i | input | NPAIRS | Per-pair matched flag |
| clear_i | input | 1 | Clears error counter and error-address register |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | 64 | Write data from host |
| wr_bank0_o | output | 32 | Half word to bank 0 |
| wr_bank1_o | output | 32 | Half word to bank 1 |
| wr_check_o | output | 8 | Check byte to store |
| rd_valid_i | input | 1 | Read data from memory is valid |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_bank0_i | input | 32 | Half word from bank 0 |
| rd_bank1_i | input | 32 | Half word from bank 1 |
| rd_check_i | input | 8 | Stored check byte |
| rsp_valid_o | output | 1 | Response valid |
| rsp_data_o | output | 64 | Returned (possibly corrected) data |
| rsp_corrected_o | output | 1 | A single-bit error was corrected |
| rsp_err_o | output | 1 | Uncorrectable or parity error |
| halt_o | output | 1 | Sticky halt request |
| pair_disable_o | output | NPAIRS | Pair-disable register |
| ce_count_o | output | CNT_W | Saturating corrected-error count |
| err_addr_o | output | ADDR_W | Address of first error |
| err_valid_o | output | 1 | err_addr_o holds a capture |

## Verification
Unlike normal traffic, erroneous codewords cannot come from the block's own write path. The bench therefore takes the check byte the block produces, flips chosen codeword bits itself, and drives the corrupted word back on the read banks. The flips are placed in data bits, in check bits, and in pairs within one byte. This reaches the corrected case, the uncorrectable case and the undetected parity case. The saturation of the counter is reached with a small CNT_W and a sweep across all 72 single-bit positions. That sweep also shows that every column of the code corrects.

// File: rtl/mck_pkg.sv
// Package: shared constants and the column generator of the (72,64)
// odd-weight-column code. Assumes the data word is exactly 64 bits.
package mck_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int HALF_W = DATA_W / 2;
    localparam int NBYTES = DATA_W / 8;

    // Column of data bit idx: weight-3 values ascending, then weight-5.
    function automatic logic [CHK_W-1:0] hcol(input int idx);
        int n;
        n = 0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 0; v < 256; v++) begin
                if ($countones(v) == w) begin
                    if (n == idx) return CHK_W'(v);
                    n++;
                end
            end
        end
        return '0;
    endfunction

    // Set of data bits that feed check bit r.
    function automatic logic [DATA_W-1:0] row_mask(input int r);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0]  c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = hcol(i);
            m[i] = c[r];
        end
        return m;
    endfunction
endpackage

// File: rtl/mck_encode.sv
// Check-byte generator: produces code check bits or byte-parity bits
// for a 64-bit word. Purely combinational; assumes mode is stable.
module mck_encode
    import mck_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic              ecc_i,
    output logic [CHK_W-1:0]  check_o
);
    logic [CHK_W-1:0] code_bits;
    logic [CHK_W-1:0] par_bits;

    // One XOR tree per check row of the code.
    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        localparam logic [DATA_W-1:0] MASK = row_mask(r);
        assign code_bits[r] = ^(data_i & MASK);
    end

    // One even-parity bit per data byte.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign par_bits[k] = ^data_i[8*k +: 8];
    end

    assign check_o = ecc_i ? code_bits : par_bits;
endmodule

// File: rtl/mck_decode.sv
// Read checker: recomputes the check byte, forms the syndrome, corrects
// a single-bit error in code mode and classifies the word. Combinational.
module mck_decode
    import mck_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  check_i,
    input  logic              ecc_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corrected_o,
    output logic              error_o
);
    logic [CHK_W-1:0]  recomputed;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip;
    logic              nonzero;
    logic              single;

    mck_encode u_enc (
        .data_i  (data_i),
        .ecc_i   (ecc_i),
        .check_o (recomputed)
    );

    assign syn     = recomputed ^ check_i;
    assign nonzero = |syn;

    // Match the syndrome against each data column.
    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        localparam logic [CHK_W-1:0] COL = hcol(i);
        assign flip[i] = (syn == COL);
    end

    // A data-column hit or a unit syndrome is a single-bit error.
    assign single = (|flip) || $onehot(syn);

    // Classify and correct according to the effective mode.
    always_comb begin
        if (ecc_i) begin
            data_o      = data_i ^ flip;
            corrected_o = nonzero && single;
            error_o     = nonzero && !single;
        end else begin
            data_o      = data_i;
            corrected_o = 1'b0;
            error_o     = nonzero;
        end
    end
endmodule

// File: rtl/mck_status.sv
// Error bookkeeping: sticky halt, pair-disable register, saturating
// corrected-error counter and first-error address capture.
// Assumes events arrive as one-cycle pulses with the read response.
module mck_status #(
    parameter int ADDR_W = 16,
    parameter int NPAIRS = 4,
    parameter int CNT_W  = 8,
    localparam int PAIR_W = $clog2(NPAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              ev_valid_i,
    input  logic              ev_corr_i,
    input  logic              ev_err_i,
    input  logic              ev_ecc_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic [PAIR_W-1:0] ev_pair_i,
    output logic              halt_o,
    output logic [NPAIRS-1:0] pair_disable_o,
    output logic [CNT_W-1:0]  ce_count_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic              err_valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic corr_ev;
    logic err_ev;
    assign corr_ev = ev_valid_i && ev_corr_i;
    assign err_ev  = ev_valid_i && ev_err_i;

    // Sticky halt request on any uncorrectable or parity error.
    always_ff @(posedge clk) begin
        if (!rst_n)      halt_o <= 1'b0;
        else if (err_ev) halt_o <= 1'b1;
    end

    // Mark the failing pair when a code-mode error is uncorrectable.
    always_ff @(posedge clk) begin
        if (!rst_n)                pair_disable_o <= '0;
        else if (err_ev && ev_ecc_i) pair_disable_o[ev_pair_i] <= 1'b1;
    end

    // Saturating corrected-error counter, cleared by firmware.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)                ce_count_o <= '0;
        else if (corr_ev && ce_count_o != CNT_MAX) ce_count_o <= ce_count_o + 1'b1;
    end

    // Capture the first erroneous address until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            err_valid_o <= 1'b0;
            err_addr_o  <= '0;
        end else if ((corr_ev || err_ev) && !err_valid_o) begin
            err_valid_o <= 1'b1;
            err_addr_o  <= ev_addr_i;
        end
    end
endmodule

// File: rtl/mck_top.sv
// Selectable code/parity memory checker. Steers the write word across
// two interleaved banks with its check byte, checks and corrects read
// words with one register stage, and tracks errors per matched pair.
// Assumes NPAIRS is a power of two of at least 2.
module mck_top
    import mck_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NPAIRS = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_mode_i,
    input  logic [NPAIRS-1:0] pair_matched_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [63:0]       wr_data_i,
    output logic [31:0]       wr_bank0_o,
    output logic [31:0]       wr_bank1_o,
    output logic [7:0]        wr_check_o,
    input  logic              rd_valid_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [31:0]       rd_bank0_i,
    input  logic [31:0]       rd_bank1_i,
    input  logic [7:0]        rd_check_i,
    output logic              rsp_valid_o,
    output logic [63:0]       rsp_data_o,
    output logic              rsp_corrected_o,
    output logic              rsp_err_o,
    output logic              halt_o,
    output logic [NPAIRS-1:0] pair_disable_o,
    output logic [CNT_W-1:0]  ce_count_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic              err_valid_o
);
    localparam int PAIR_W = $clog2(NPAIRS);

    // ---------------- write path ----------------
    logic [PAIR_W-1:0] wr_pair;
    logic              wr_ecc;
    logic              wr_addr_unused;

    assign wr_pair        = wr_addr_i[ADDR_W-1 -: PAIR_W];
    assign wr_ecc         = ecc_mode_i && pair_matched_i[wr_pair];
    assign wr_addr_unused = ^wr_addr_i[ADDR_W-PAIR_W-1:1];

    // Bank steering: odd word address swaps the halves.
    always_comb begin
        if (wr_addr_i[0]) begin
            wr_bank0_o = wr_data_i[63:32];
            wr_bank1_o = wr_data_i[31:0];
        end else begin
            wr_bank0_o = wr_data_i[31:0];
            wr_bank1_o = wr_data_i[63:32];
        end
    end

    mck_encode u_wr_enc (
        .data_i  (wr_data_i),
        .ecc_i   (wr_ecc),
        .check_o (wr_check_o)
    );

    // ---------------- read path ----------------
    logic [PAIR_W-1:0] rd_pair;
    logic              rd_ecc;
    logic [63:0]       rd_word;
    logic [63:0]       dec_data;
    logic              dec_corr;
    logic              dec_err;

    assign rd_pair = rd_addr_i[ADDR_W-1 -: PAIR_W];
    assign rd_ecc  = ecc_mode_i && pair_matched_i[rd_pair];
    assign rd_word = rd_addr_i[0] ? {rd_bank0_i, rd_bank1_i}
                                  : {rd_bank1_i, rd_bank0_i};

    mck_decode u_dec (
        .data_i      (rd_word),
        .check_i     (rd_check_i),
        .ecc_i       (rd_ecc),
        .data_o      (dec_data),
        .corrected_o (dec_corr),
        .error_o     (dec_err)
    );

    // Response register: one fixed cycle of latency for every outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o     <= 1'b0;
            rsp_data_o      <= '0;
            rsp_corrected_o <= 1'b0;
            rsp_err_o       <= 1'b0;
        end else begin
            rsp_valid_o     <= rd_valid_i;
            rsp_data_o      <= rd_valid_i ? dec_data : '0;
            rsp_corrected_o <= rd_valid_i && dec_corr;
            rsp_err_o       <= rd_valid_i && dec_err;
        end
    end

    mck_status #(
        .ADDR_W (ADDR_W),
        .NPAIRS (NPAIRS),
        .CNT_W  (CNT_W)
    ) u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (clear_i),
        .ev_valid_i     (rd_valid_i),
        .ev_corr_i      (dec_corr),
        .ev_err_i       (dec_err),
        .ev_ecc_i       (rd_ecc),
        .ev_addr_i      (rd_addr_i),
        .ev_pair_i      (rd_pair),
        .halt_o         (halt_o),
        .pair_disable_o (pair_disable_o),
        .ce_count_o     (ce_count_o),
        .err_addr_o     (err_addr_o),
        .err_valid_o    (err_valid_o)
    );
endmodule

// File: rtl/mck_checker.sv
// Checker: temporal properties of the checker's ports, bound to mck_top.
module mck_checker #(
    parameter int ADDR_W = 16,
    parameter int NPAIRS = 4,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              rd_valid_i,
    input logic              rsp_valid_o,
    input logic              rsp_corrected_o,
    input logic              rsp_err_o,
    input logic              halt_o,
    input logic [NPAIRS-1:0] pair_disable_o,
    input logic [CNT_W-1:0]  ce_count_o,
    input logic [ADDR_W-1:0] err_addr_o,
    input logic              err_valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid_i |=> rsp_valid_o); // R3
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid_i |=> !rsp_valid_o); // R3
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid_o |-> !(rsp_corrected_o && rsp_err_o)); // R4
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid_o && rsp_err_o) |-> halt_o); // R5
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halt_o |=> halt_o); // R5
    AST_DISABLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((pair_disable_o & $past(pair_disable_o)) == $past(pair_disable_o))); // R6
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n) (ce_count_o == CNT_MAX && !clear_i) |=> ce_count_o == CNT_MAX); // R9
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clear_i |=> (ce_count_o == '0 && !err_valid_o)); // R10
    AST_ERRADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (err_valid_o && !clear_i) |=> (err_valid_o && $stable(err_addr_o))); // R10
endmodule

bind mck_top mck_checker #(
    .ADDR_W (ADDR_W),
    .NPAIRS (NPAIRS),
    .CNT_W  (CNT_W)
) u_mck_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .clear_i         (clear_i),
    .rd_valid_i      (rd_valid_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_corrected_o (rsp_corrected_o),
    .rsp_err_o       (rsp_err_o),
    .halt_o          (halt_o),
    .pair_disable_o  (pair_disable_o),
    .ce_count_o      (ce_count_o),
    .err_addr_o      (err_addr_o),
    .err_valid_o     (err_valid_o)
);

// File: tb/tb_mck_top.sv
module tb_mck_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int NPAIRS = 4;
    localparam int CNT_W  = 3;
    localparam int NVEC   = 10;
    localparam logic [6:0] NONE = 7'd127;

    // {exp_class[1:0], ecc, flip2[6:0], flip1[6:0], addr[15:0], data[63:0]}
    // exp_class: 0 clean, 1 corrected, 2 error
    localparam logic [96:0] VEC [NVEC] = '{
        {2'd0, 1'b1, NONE,  NONE,  16'h0000, 64'h0123_4567_89AB_CDEF}, // R11
        {2'd1, 1'b1, NONE,  7'd5,  16'h0001, 64'hDEAD_BEEF_CAFE_F00D}, // R4
        {2'd1, 1'b1, NONE,  7'd63, 16'h4002, 64'h5555_AAAA_0F0F_F0F0}, // R4
        {2'd1, 1'b1, NONE,  7'd70, 16'h4003, 64'h0000_0000_0000_0001}, // R4
        {2'd2, 1'b0, NONE,  7'd8,  16'h0004, 64'h1111_2222_3333_4444}, // R7
        {2'd0, 1'b0, 7'd10, 7'd9,  16'h0005, 64'h8888_9999_AAAA_BBBB}, // R7
        {2'd2, 1'b1, NONE,  7'd20, 16'hC006, 64'hFFFF_0000_FFFF_0000}, // R8
        {2'd2, 1'b1, 7'd40, 7'd3,  16'h8007, 64'h0246_8ACE_1357_9BDF}, // R5
        {2'd1, 1'b1, NONE,  7'd0,  16'h0008, 64'hFFFF_FFFF_FFFF_FFFF}, // R4
        {2'd1, 1'b1, NONE,  7'd64, 16'h4009, 64'h0000_0000_0000_0000}  // R4
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ecc_mode_i = 1'b1;
    logic [NPAIRS-1:0] pair_matched_i = 4'b0111;
    logic clear_i = 1'b0;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [63:0] wr_data_i = '0;
    logic [31:0] wr_bank0_o, wr_bank1_o;
    logic [7:0] wr_check_o;
    logic rd_valid_i = 1'b0;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic [31:0] rd_bank0_i = '0, rd_bank1_i = '0;
    logic [7:0] rd_check_i = '0;
    logic rsp_valid_o, rsp_corrected_o, rsp_err_o, halt_o, err_valid_o;
    logic [63:0] rsp_data_o;
    logic [NPAIRS-1:0] pair_disable_o;
    logic [CNT_W-1:0] ce_count_o;
    logic [ADDR_W-1:0] err_addr_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] col_tab [64];
    int model_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mck_top #(.ADDR_W(ADDR_W), .NPAIRS(NPAIRS), .CNT_W(CNT_W)) dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_code(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++) if (d[i]) c ^= col_tab[i];
        return c;
    endfunction

    function automatic logic [7:0] ref_par(input logic [63:0] d);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[k] = ^d[8*k +: 8];
        return c;
    endfunction

    // Drive one read at a falling edge, sample the response one cycle later.
    task automatic do_read(input logic [15:0] a, input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        rd_valid_i = 1'b1;
        rd_addr_i  = a;
        rd_bank0_i = a[0] ? d[63:32] : d[31:0];
        rd_bank1_i = a[0] ? d[31:0]  : d[63:32];
        rd_check_i = c;
        @(negedge clk);
        rd_valid_i = 1'b0;
    endtask

    task automatic check_reset_state();
        check("R11 rsp_valid", 64'(rsp_valid_o), 0);
        check("R11 rsp_data", rsp_data_o, 0);
        check("R5 halt", 64'(halt_o), 0);
        check("R6 disable", 64'(pair_disable_o), 0);
        check("R9 count", 64'(ce_count_o), 0);
        check("R10 err_valid", 64'(err_valid_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] first_addr;
        logic        have_first;
        n = 0;
        for (int w = 3; w <= 5; w += 2)
            for (int v = 0; v < 256; v++)
                if ($countones(v) == w && n < 64) begin
                    col_tab[n] = 8'(v);
                    n++;
                end
        have_first = 1'b0;
        first_addr = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [63:0] d, dorig, dexp;
            logic [7:0]  c, cexp;
            logic [15:0] a;
            logic [6:0]  f1, f2;
            logic        ecc, eff;
            logic [1:0]  cls;
            {cls, ecc, f2, f1, a, dorig} = VEC[v];
            ecc_mode_i = ecc;
            wr_addr_i  = a;
            wr_data_i  = dorig;
            #1;
            eff  = ecc && pair_matched_i[a[15:14]];
            cexp = eff ? ref_code(dorig) : ref_par(dorig);
            check(eff ? "R1 code check" : "R8 R1 parity check", 64'(wr_check_o), 64'(cexp));
            check("R2 bank0", 64'(wr_bank0_o), 64'(a[0] ? dorig[63:32] : dorig[31:0]));
            check("R2 bank1", 64'(wr_bank1_o), 64'(a[0] ? dorig[31:0] : dorig[63:32]));
            d = dorig;
            c = wr_check_o;
            if (f1 < 64) d[f1] = ~d[f1]; else if (f1 < 72) c[f1-64] = ~c[f1-64];
            if (f2 < 64) d[f2] = ~d[f2]; else if (f2 < 72) c[f2-64] = ~c[f2-64];
            do_read(a, d, c);
            dexp = (cls == 2'd1) ? dorig : d;
            check("R3 rsp_valid", 64'(rsp_valid_o), 1);
            check("R4 R11 data", rsp_data_o, dexp);
            check("R4 corrected flag", 64'(rsp_corrected_o), 64'(cls == 2'd1));
            check("R5 R7 R8 err flag", 64'(rsp_err_o), 64'(cls == 2'd2));
            if (cls == 2'd1 && model_cnt < 7) model_cnt++;
            if (cls != 2'd0 && !have_first) begin
                have_first = 1'b1;
                first_addr = a;
            end
        end
        @(negedge clk);
        check("R3 no response when idle", 64'(rsp_valid_o), 0);
        check("R5 halt sticky", 64'(halt_o), 1);
        check("R6 only pair 2 disabled", 64'(pair_disable_o), 64'h4);
        check("R9 count", 64'(ce_count_o), 64'(model_cnt));
        check("R10 first error addr", 64'(err_addr_o), 64'(first_addr));
        check("R10 err_valid", 64'(err_valid_o), 1);

        // Clear: counter and capture drop, halt stays
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        check("R9 cleared count", 64'(ce_count_o), 0);
        check("R10 cleared err_valid", 64'(err_valid_o), 0);
        check("R10 halt kept after clear", 64'(halt_o), 1);

        // Sweep all 72 single-bit positions on a matched pair
        ecc_mode_i = 1'b1;
        for (int p = 0; p < 72; p++) begin
            logic [63:0] dd, d0;
            logic [7:0]  cc;
            d0 = 64'hA5C3_0F96_7E18_D24B ^ (64'(p) << 17);
            cc = ref_code(d0);
            dd = d0;
            if (p < 64) dd[p] = ~dd[p]; else cc[p-64] = ~cc[p-64];
            do_read(16'h4010, dd, cc);
            check($sformatf("R4 sweep bit %0d data", p), rsp_data_o, d0);
            check($sformatf("R4 sweep bit %0d flag", p), 64'(rsp_corrected_o), 1);
        end
        check("R9 saturated count", 64'(ce_count_o), 7);
        check("R10 capture after clear", 64'(err_addr_o), 64'h4010);
        check("R6 disable unchanged by corrections", 64'(pair_disable_o), 64'h4);

        // Unmatched pair with mode forced to code: still parity, odd address
        pair_matched_i = 4'b0011;
        do_read(16'h8011, 64'h1234_5678_9ABC_DEF0, ref_par(64'h1234_5678_9ABC_DEF0));
        check("R8 unmatched clean under parity", 64'(rsp_err_o), 0);
        check("R8 R2 unmatched data", rsp_data_o, 64'h1234_5678_9ABC_DEF0);

        // Reset clears sticky state
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset_state();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule